// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter Stage

This block is one stage of a wide synchronous up counter. It holds a binary count (four bits by default) that it can clear, load from a parallel input, advance by one or hold. All of these happen on the rising clock edge, and no input acts asynchronously.

Two active-high enables must both be high for the count to advance:
- `cnt_en_par` is shared by every stage of a chain.
- `cnt_en_trk` carries the look-ahead carry from the stage below.

A combinational terminal count flag, `term_cnt`, is high when the stage sits at its all-ones value and its own trickle enable is high. Wiring each stage's `term_cnt` to the next stage's `cnt_en_trk` builds a counter of any width with no glue logic. Only the lowest stage takes the global trickle enable. The clear, load and parallel enable lines are shared by all stages.

The controls follow a fixed priority: clear beats load, and load beats counting.

Top module: `ctr_stage`

## Requirements
- R1: With `clr_n` low at a rising edge, `count` becomes 0, whatever the values of `load_n`, `cnt_en_par` and `cnt_en_trk`.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count` takes the value of `load_val`, whatever the values of the two count enables.
- R3: With `clr_n` and `load_n` both high and both count enables high at a rising edge, `count` increases by one.
- R4: With `clr_n` and `load_n` both high and either count enable low at a rising edge, `count` keeps its value.
- R5: Counting from the all-ones value (15 for 4 bits) wraps `count` to 0.
- R6: `term_cnt` is high exactly when `count` is all ones and `cnt_en_trk` is high. It follows `cnt_en_trk` within the same cycle, with no clock edge.
- R7: After an edge with `clr_n` low, `term_cnt` is low.
- R8: Two stages chained through `term_cnt` into the upper stage's `cnt_en_trk`, with a shared parallel enable, count as one 8-bit binary counter. The upper stage advances only on the edge where the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | WIDTH | Value taken into the count on a load |
| cnt_en_par | input | 1 | Parallel count enable, shared across a chain |
| cnt_en_trk | input | 1 | Trickle count enable; also gates `term_cnt` |
| count | output | WIDTH | Present count |
| term_cnt | output | 1 | All-ones count with trickle enable high |

## Verification
The assertions assume every control input is a known 0 or 1 at each rising edge. They also assume the design has seen one clear edge before any past-value comparison means anything. The bench clears first and keeps every input fixed from one falling edge to the next, so each edge samples settled, defined controls. The random phase draws its controls and load data over the full legal range, with the clear and load lines weighted toward their inactive level. This leaves room for long runs of counting and carry ripple between the two stages.

// File: rtl/ctr_stage_pkg.sv
package ctr_stage_pkg;

   // Next-state operation selected at each rising edge
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_HOLD  = 2'd3
   } ctr_op_e;

endpackage

// File: rtl/ctr_op_sel.sv
// Priority decode of the control lines: clear, then load, then step, else hold.
module ctr_op_sel
   import ctr_stage_pkg::*;
(
   input  logic    clr_n,
   input  logic    load_n,
   input  logic    en_par,
   input  logic    en_trk,
   output ctr_op_e op
);

   always_comb begin
      if (!clr_n)
         op = OP_CLEAR;
      else if (!load_n)
         op = OP_LOAD;
      else if (en_par && en_trk)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/ctr_inc.sv
// Incrementer built as a toggle chain: a bit flips when all lower bits are one.
module ctr_inc #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt,
   output logic             all_ones
);

   logic [WIDTH:0] carry;

   assign carry[0] = 1'b1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign nxt[i]     = cur[i] ^ carry[i];
      assign carry[i+1] = carry[i] & cur[i];
   end

   assign all_ones = carry[WIDTH];

endmodule

// File: rtl/ctr_tc.sv
// Look-ahead carry output: gated by the trickle enable only.
module ctr_tc (
   input  logic all_ones,
   input  logic en_trk,
   output logic tc
);

   assign tc = all_ones & en_trk;

endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
   import ctr_stage_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] load_val,
   input  logic             cnt_en_par,
   input  logic             cnt_en_trk,
   output logic [WIDTH-1:0] count,
   output logic             term_cnt
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ctr_stage: WIDTH must be at least 1");
   end

   ctr_op_e          op;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_inc;
   logic             at_max;

   ctr_op_sel u_sel (
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_par (cnt_en_par),
      .en_trk (cnt_en_trk),
      .op     (op)
   );

   ctr_inc #(.WIDTH(WIDTH)) u_inc (
      .cur      (cnt_q),
      .nxt      (cnt_inc),
      .all_ones (at_max)
   );

   ctr_tc u_tc (
      .all_ones (at_max),
      .en_trk   (cnt_en_trk),
      .tc       (term_cnt)
   );

   always_ff @(posedge clk) begin
      case (op)
         OP_CLEAR: cnt_q <= '0;
         OP_LOAD:  cnt_q <= load_val;
         OP_STEP:  cnt_q <= cnt_inc;
         default:  cnt_q <= cnt_q;
      endcase
   end

   assign count = cnt_q;

endmodule

// File: rtl/ctr_stage_chk.sv
module ctr_stage_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic [WIDTH-1:0] load_val,
   input logic             cnt_en_par,
   input logic             cnt_en_trk,
   input logic [WIDTH-1:0] count,
   input logic             term_cnt
);

   localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

   // Goes high after the first edge so that no property sees pre-clock values
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   p_clear_wins_r1: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> count == '0);

   p_load_r2: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> count == $past(load_val));

   p_step_r3: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_par && cnt_en_trk) |=> count == WIDTH'($past(count) + 1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !(cnt_en_par && cnt_en_trk)) |=> $stable(count));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_par && cnt_en_trk && count == MAXV) |=> count == '0);

   p_tc_needs_trk_r6: assert property (@(posedge clk) disable iff (!armed)
      term_cnt |-> cnt_en_trk);

   p_tc_max_only_r6: assert property (@(posedge clk) disable iff (!armed)
      (count != MAXV) |-> !term_cnt);

   p_tc_set_r6: assert property (@(posedge clk) disable iff (!armed)
      (count == MAXV && cnt_en_trk) |-> term_cnt);

   p_tc_low_after_clear_r7: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> !term_cnt);

endmodule

bind ctr_stage ctr_stage_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .clr_n      (clr_n),
   .load_n     (load_n),
   .load_val   (load_val),
   .cnt_en_par (cnt_en_par),
   .cnt_en_trk (cnt_en_trk),
   .count      (count),
   .term_cnt   (term_cnt)
);

// File: tb/tb_ctr_stage.sv
module tb_ctr_stage;

   logic       clk = 1'b0;
   logic       clr_n = 1'b1;
   logic       load_n = 1'b1;
   logic [7:0] ld8 = 8'h00;
   logic       en_p = 1'b0;
   logic       en_t = 1'b0;
   logic [3:0] q_lo, q_hi;
   logic       tc_lo, tc_hi;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [7:0] q;
      logic       tlo;
      logic       thi;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] model = 8'h00;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   // Lower stage takes the global trickle enable (R8 chain)
   ctr_stage #(.WIDTH(4)) dut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(ld8[3:0]),
      .cnt_en_par(en_p), .cnt_en_trk(en_t), .count(q_lo), .term_cnt(tc_lo)
   );

   // Upper stage is enabled by the lower stage's terminal count
   ctr_stage #(.WIDTH(4)) dut_hi (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(ld8[7:4]),
      .cnt_en_par(en_p), .cnt_en_trk(tc_lo), .count(q_hi), .term_cnt(tc_hi)
   );

   // Driver: set inputs at the falling edge and push the expected result
   // of the next rising edge.
   task automatic apply(input logic c, input logic l, input logic [7:0] d,
                        input logic p, input logic t, input string tag);
      exp_t e;
      @(negedge clk);
      clr_n = c; load_n = l; ld8 = d; en_p = p; en_t = t;
      if (!c)          model = 8'h00;
      else if (!l)     model = d;
      else if (p && t) model = model + 8'd1;
      e.q   = model;
      e.tlo = (model[3:0] == 4'hF) && t;
      e.thi = (model[7:4] == 4'hF) && e.tlo;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: 2 ns after each rising edge, compare against the queue head
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if ({q_hi, q_lo} !== e.q) begin
               misses++;
               $display("FAIL %s count: actual %02h expected %02h", e.tag, {q_hi, q_lo}, e.q);
            end
            if (tc_lo !== e.tlo) begin
               misses++;
               $display("FAIL %s low term_cnt: actual %b expected %b", e.tag, tc_lo, e.tlo);
            end
            if (tc_hi !== e.thi) begin
               misses++;
               $display("FAIL %s high term_cnt: actual %b expected %b", e.tag, tc_hi, e.thi);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      // R1: clear wins over an active load and both enables
      apply(1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, "R1 clear over load");
      apply(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R1 clear over count");

      // R2: load while enabled; the enables do not step the count
      apply(1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, "R2 load");
      apply(1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, "R2 reload no step");

      // R3: counting
      for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R3 step");

      // R4: hold with either enable low
      apply(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R4 hold par low");
      apply(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R4 hold trk low");

      // R8: carry from the lower stage into the upper stage
      apply(1'b1, 1'b0, 8'h0E, 1'b0, 1'b0, "R2 load 0E");
      apply(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 to 0F");
      apply(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 carry to 10");

      // R6: terminal count follows the trickle enable at all ones
      apply(1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, "R6 FF trk high");
      apply(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R6 FF trk low");
      apply(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R6 FF trk high again");

      // R5: wrap of both stages
      apply(1'b1, 1'b0, 8'hFD, 1'b0, 1'b0, "R2 load FD");
      for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R5 count through wrap");

      // R7: clear from all ones drops the terminal count
      apply(1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, "R2 load FF");
      apply(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R7 clear from FF");

      // Random mix of all controls (R1 to R8)
      for (int i = 0; i < 300; i++) begin
         logic c, l;
         c = ($urandom_range(0, 19) != 0);
         l = ($urandom_range(0, 9) != 0);
         apply(c, l, 8'($urandom), 1'($urandom_range(0, 7) != 0),
               1'($urandom_range(0, 7) != 0), "R8 random");
      end

      @(negedge clk);
      en_p = 1'b0;
      en_t = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule